// File: doc/BRIEF.md
# Status pin mode controller

This block drives the single active-low status output of a flash-style memory from the signals of its write state machine. Software picks what the output means with a two-write command on a small bus port (a write strobe and a data byte). The first write is the configuration opcode 0xB8, and the second write carries a two-bit mode code.

In the default mode the output follows the busy flag of the write state machine, so a memory controller can hold off accesses while the device works. In the three pulse modes the output stays high and drops low for a fixed number of clock cycles when a selected operation completes. The selectable operations are erase completion, program completion, or either. The cycle count comes from a parameter; at 100 MHz, 25 cycles give the nominal 250 ns.

An erase completion counts only when no further queued block erase is pending. A sequence of queued erases therefore raises one pulse, at its end.

Top module: `sts_pin_ctrl`

## Requirements
- R1: After reset the mode is 00 (level mode), the command decoder waits for an opcode, no pulse is in progress, and sts_n equals the inverse of wsm_busy.
- R2: A write of 0xB8 followed by any second write loads data bits 1:0 of the second write into the mode. Bits 7:2 are ignored. The new mode applies from the clock edge that takes the second write.
- R3: A first write whose data is not 0xB8 is ignored: the mode does not change, and the decoder keeps waiting for 0xB8.
- R4: In mode 00, sts_n equals the inverse of wsm_busy in the same cycle, and the done inputs have no effect on it.
- R5: In mode 01, a qualifying erase completion sampled at a clock edge drives sts_n low for exactly PULSE_CYCLES cycles after that edge, and then sts_n returns high. wsm_busy has no effect in any pulse mode.
- R6: In mode 10, a prog_done sampled at a clock edge gives the same low pulse, and erase completions give no pulse.
- R7: In mode 11, either a qualifying erase completion or a prog_done gives the pulse.
- R8: An erase_done with erase_queued high marks an intermediate block of a queued erase and gives no pulse. Only an erase_done with erase_queued low qualifies.
- R9: A qualifying event during a pulse restarts the timer, so sts_n stays low for PULSE_CYCLES cycles after the last event, with no high gap.
- R10: Taking a configuration write cancels any pulse in progress from the same clock edge. A completion in that same cycle gives no pulse.
- R11: The write that follows 0xB8 is always taken as configuration data, even if it is 0xB8 itself, and the decoder then returns to waiting for an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_data | input | 8 | Write data byte |
| wsm_busy | input | 1 | Write state machine busy |
| erase_done | input | 1 | One-cycle erase block finished event |
| erase_queued | input | 1 | Another queued block erase follows |
| prog_done | input | 1 | One-cycle program finished event |
| sts_n | output | 1 | Active-low status output |

## Verification
The bench builds the block with PULSE_CYCLES set to 5. Every pulse can then be counted cycle by cycle, and a pulse is short enough that a restart or a cancel lands in its middle, with several cycles still left. With this width, an extended pulse (PULSE_CYCLES cycles after the last event) is clearly different from a non-restarted one (PULSE_CYCLES minus the elapsed cycles). A cancel two cycles into a pulse is also clearly visible.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam logic [7:0] CFG_OPCODE = 8'hB8;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_PROG  = 2'b10,
    MODE_BOTH  = 2'b11
  } sts_mode_e;

  // Whether a completion starts a pulse under the given mode
  function automatic logic pulse_wanted(sts_mode_e mode, logic er_fin, logic pr_fin);
    case (mode)
      MODE_ERASE: pulse_wanted = er_fin;
      MODE_PROG:  pulse_wanted = pr_fin;
      MODE_BOTH:  pulse_wanted = er_fin | pr_fin;
      default:    pulse_wanted = 1'b0;
    endcase
  endfunction

  // Cycles needed to cover a time span, rounded up
  function automatic int unsigned span_cycles(int unsigned span_ns, int unsigned period_ns);
    span_cycles = (span_ns + period_ns - 1) / period_ns;
  endfunction
endpackage

// File: rtl/sts_cmd_decoder.sv
module sts_cmd_decoder
  import sts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_data,
  output logic       cfg_load,
  output sts_mode_e  cfg_code,
  output logic       armed
);
  typedef enum logic {DEC_IDLE = 1'b0, DEC_ARMED = 1'b1} dec_state_e;
  dec_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      DEC_IDLE:  if (bus_wr && bus_data == CFG_OPCODE) state_d = DEC_ARMED;
      DEC_ARMED: if (bus_wr) state_d = DEC_IDLE;
      default:   state_d = DEC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= DEC_IDLE;
    else        state_q <= state_d;

  assign armed    = (state_q == DEC_ARMED);
  assign cfg_load = armed && bus_wr;
  assign cfg_code = sts_mode_e'(bus_data[1:0]);

  a_r3_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && bus_wr && bus_data != CFG_OPCODE) |=> !armed);
  a_r11_consume_second: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bus_wr) |=> !armed);
endmodule

// File: rtl/sts_mode_reg.sv
module sts_mode_reg
  import sts_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  sts_mode_e code,
  output sts_mode_e mode
);
  sts_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    mode_q <= MODE_LEVEL;
    else if (load) mode_q <= code;

  assign mode = mode_q;

  a_r2_store_code: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode == $past(code)));
  a_r2_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode));
endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
  parameter int unsigned PULSE_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic active
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt_q <= '0;
    else if (cancel)       cnt_q <= '0;
    else if (start)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign active = (cnt_q != '0);

  initial a_r5_width_nonzero: assert (PULSE_CYCLES >= 1);

  a_r10_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !active);
  a_r9_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cancel) |=> (cnt_q == LOAD_VAL));
  a_r5_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> !active);
endmodule

// File: rtl/sts_pin_ctrl.sv
module sts_pin_ctrl
  import sts_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = span_cycles(250, 10)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_data,
  input  logic       wsm_busy,
  input  logic       erase_done,
  input  logic       erase_queued,
  input  logic       prog_done,
  output logic       sts_n
);
  logic      cfg_load;
  sts_mode_e cfg_code;
  logic      dec_armed;
  sts_mode_e mode;
  logic      erase_final;
  logic      pulse_fire;
  logic      pulse_active;

  sts_cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_data(bus_data),
    .cfg_load(cfg_load), .cfg_code(cfg_code), .armed(dec_armed)
  );

  sts_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .code(cfg_code), .mode(mode)
  );

  // Only the last block of a queued erase counts as a completion
  assign erase_final = erase_done && !erase_queued;
  assign pulse_fire  = pulse_wanted(mode, erase_final, prog_done);

  sts_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(pulse_fire), .cancel(cfg_load),
    .active(pulse_active)
  );

  assign sts_n = (mode == MODE_LEVEL) ? !wsm_busy : !pulse_active;

  a_r8_queued_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ERASE && erase_done && erase_queued && !pulse_active && !cfg_load)
      |=> sts_n);
  a_r6_erase_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PROG && !prog_done && !pulse_active && !cfg_load) |=> sts_n);
  a_r7_either_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BOTH && (prog_done || erase_final) && !cfg_load) |=> !sts_n);
  a_r1_armed_idle_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_armed) |-> $past(bus_wr));
endmodule

// File: tb/tb_sts_pin_ctrl.sv
module tb_sts_pin_ctrl;
  localparam int unsigned P = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic wsm_busy = 1'b0, erase_done = 1'b0, erase_queued = 1'b0, prog_done = 1'b0;
  logic sts_n;
  int n_run = 0, n_fail = 0;

  sts_pin_ctrl #(.PULSE_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_data(bus_data),
    .wsm_busy(wsm_busy), .erase_done(erase_done), .erase_queued(erase_queued),
    .prog_done(prog_done), .sts_n(sts_n)
  );

  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(logic [7:0] d);
    bus_wr = 1'b1; bus_data = d; tick(); bus_wr = 1'b0; bus_data = 8'h00;
  endtask

  task automatic set_mode(logic [7:0] d);
    bus_write(8'hB8); bus_write(d);
  endtask

  // kind: 0 = final erase, 1 = program, 2 = queued erase
  task automatic fire(int kind);
    erase_done = (kind != 1); erase_queued = (kind == 2); prog_done = (kind == 1);
    tick();
    erase_done = 1'b0; erase_queued = 1'b0; prog_done = 1'b0;
  endtask

  // Count low cycles from now until sts_n returns high
  task automatic measure(output int lows);
    lows = 0;
    for (int i = 0; i < 4 * P; i++) begin
      if (sts_n) break;
      lows++; tick();
    end
  endtask

  task automatic t_reset();
    check("R1 idle high", sts_n, 1);
    wsm_busy = 1'b1; #1;
    check("R1 level after reset", sts_n, 0);
    wsm_busy = 1'b0; #1;
  endtask

  task automatic t_level();
    int l;
    wsm_busy = 1'b1; #1; check("R4 busy low", sts_n, 0);
    wsm_busy = 1'b0; #1; check("R4 ready high", sts_n, 1);
    fire(1); check("R4 done no effect", sts_n, 1);
    fire(0); measure(l); check("R4 erase no effect", l, 0);
  endtask

  task automatic t_erase_mode();
    int l;
    set_mode(8'hFD);                     // reserved bits set, code 01
    wsm_busy = 1'b1; #1; check("R5 busy ignored", sts_n, 1);
    wsm_busy = 1'b0;
    fire(0); measure(l); check("R5 erase pulse width", l, P);
    check("R2 reserved bits ignored", l, P);
    fire(1); measure(l); check("R5 program ignored", l, 0);
    fire(2); measure(l); check("R8 queued erase no pulse", l, 0);
    fire(2); fire(2); fire(0); measure(l); check("R8 last of queue pulses", l, P);
  endtask

  task automatic t_prog_mode();
    int l;
    set_mode(8'h02);
    fire(0); measure(l); check("R6 erase ignored", l, 0);
    fire(1); measure(l); check("R6 program pulse", l, P);
  endtask

  task automatic t_both_mode();
    int l;
    set_mode(8'h03);
    fire(0); measure(l); check("R7 erase pulse", l, P);
    fire(1); measure(l); check("R7 program pulse", l, P);
    fire(1); tick(); fire(0); measure(l); check("R9 restart extends", l, P);
  endtask

  task automatic t_bad_opcode();
    int l;
    bus_write(8'h41); bus_write(8'h00);  // not a command; 00 must not load
    fire(1); measure(l); check("R3 non-opcode ignored", l, P);
  endtask

  task automatic t_cancel();
    fire(1);                             // pulse starts, mode 11
    bus_write(8'hB8);
    check("R10 still low while armed", sts_n, 0);
    bus_write(8'h03);
    check("R10 cancelled", sts_n, 1);
    bus_write(8'hB8);
    prog_done = 1'b1; bus_write(8'h01); prog_done = 1'b0;
    check("R10 event during load dropped", sts_n, 1);
  endtask

  task automatic t_opcode_as_data();
    int l;
    set_mode(8'h02);
    bus_write(8'hB8); bus_write(8'hB8);  // second B8 is data: code 00
    wsm_busy = 1'b1; #1; check("R11 B8 as data gives level", sts_n, 0);
    wsm_busy = 1'b0; #1;
    bus_write(8'h01);                    // decoder idle: ignored
    fire(0); measure(l); check("R11 decoder back to idle", l, 0);
    set_mode(8'h00);
    check("R2 back to level", sts_n, 1);
  endtask

  initial begin
    fork
      begin
        #22 rst_n = 1'b1; tick();
        t_reset();
        t_level();
        t_erase_mode();
        t_prog_mode();
        t_both_mode();
        t_bad_opcode();
        t_cancel();
        t_opcode_as_data();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule